// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a translation miss by searching a hashed page table held in ordinary memory. A requester hands it a 32-bit effective address, a write flag and a side select (data or instruction). The walker picks one of sixteen segment registers from the top four address bits and takes that register's 24-bit segment ID. It then forms a primary hash and reads the key word of each entry in the selected 8-entry group, one at a time, over a word-wide memory port with a request/valid handshake. If none of the eight keys match, it repeats the search in the group addressed by the complemented hash.

On a match, the walker fetches the second word of the entry and returns a physical address built from the real page number and the page offset. If neither group matches, or the table base register is zero, it reports a translation fault. A data-side fault also updates a two-bit fault-status register and a fault-address register. The walker handles one request at a time. It holds its result until the requester acknowledges it.

The controller has six states:
- IDLE waits for a request. From IDLE, **accept** leads to FETCH_KEY, and **empty-table** leads to FAULT.
- FETCH_KEY reads a key word. **key-arrived** leads to COMPARE.
- COMPARE checks the word against the search key. **hit** leads to FETCH_DATA. **next-slot** leads back to FETCH_KEY. **switch-to-secondary** also leads back to FETCH_KEY, with the slot reset. **exhausted** leads to FAULT.
- FETCH_DATA reads the second word. **data-arrived** leads to DONE.
- DONE and FAULT each hold their result. From either, **ack** leads back to IDLE.

Top module: `hpt_walker`

## Requirements
- R1: After reset, busy, done, fault and mem_req are 0, and fault_status and fault_addr are 0.
- R2: The segment ID is bits 23:0 of the segment register selected by req_ea[31:28]. The primary hash is (req_ea[27:12] zero-extended XOR segment ID) taken to 23 bits. For slot s, the key-word address is {table_base[31:16],16'h0} OR (hash[9:0] << 6) OR ((hash[18:10] AND table_base[8:0]) << 16) OR (s × 8).
- R3: The search key is {1'b1, segment ID[23:0], select bit, req_ea[27:22]}, with the select bit at bit 6. The primary group is read from slot 0 up to slot 7 with the select bit 0, and the search stops at the first key word that equals the search key. A hit in slot s costs s+1 key reads plus one data read.
- R4: After eight primary misses, the secondary hash is the bitwise complement of the primary hash, within 23 bits. The secondary group is searched the same way with the select bit 1. A key that differs only in the select bit never matches.
- R5: On a hit, the walker reads the word at the key address + 4. The result pa is {that word[31:12], req_ea[11:0]}.
- R6: When a data-side walk misses all 16 entries, fault rises. fault_status becomes {write, 1'b1}: bit 0 is no-translation and bit 1 is store. fault_addr becomes the effective address.
- R7: An instruction-side fault raises fault but leaves fault_status and fault_addr unchanged.
- R8: A request that arrives while table_base is zero faults on the next cycle and makes no memory read.
- R9: busy is high from the cycle after acceptance until acknowledgement. A req_valid that arrives while busy is ignored.
- R10: done or fault, and pa, stay stable until ack. The walker is idle on the cycle after ack.
- R11: Once mem_req is raised, it stays high with a stable mem_addr until mem_valid arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk (taken only when idle) |
| req_ea | input | 32 | Effective address to translate |
| req_write | input | 1 | Access is a store |
| req_data_side | input | 1 | 1 = data side, 0 = instruction side |
| seg_regs | input | 512 | Sixteen 32-bit segment registers; register i is at bits 32i+31:32i |
| table_base | input | 32 | Table origin in bits 31:16, size mask in bits 8:0 |
| busy | output | 1 | Walk in progress or result pending |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 32 | Byte address of the word |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Translation succeeded |
| fault | output | 1 | Translation failed |
| pa | output | 32 | Physical address (valid with done) |
| ack | input | 1 | Release the result |
| fault_status | output | 2 | Bit 0 no-translation, bit 1 store |
| fault_addr | output | 32 | Effective address of the last data fault |

## Verification
A wrong slot or group-select state shows at once on the memory port: the next FETCH_KEY cycle puts out an address that departs from the hashed address formula, so the walk either misses a placed entry or returns a decoy page number. The bench plants entries in the last primary slot and in secondary slots, plus a decoy that differs only in the select bit. It counts memory reads per walk, so a search that stops early or late, or a secondary pass that is skipped, shows as a wrong read count or a wrong pa within one walk. Fault-register corruption shows on fault_status and fault_addr right after the FAULT entry, and an instruction fault that follows a data fault tests the retention case.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH_KEY,
        S_COMPARE,
        S_FETCH_DATA,
        S_DONE,
        S_FAULT
    } walk_state_t;

    localparam int WORD_W   = 32;
    localparam int HASH_W   = 23;
    localparam int PAGE_SH  = 12;
endpackage

// File: rtl/pgw_seg_mux.sv
module pgw_seg_mux #(
    parameter int SEG_CNT = 16,
    parameter int VSID_W  = 24,
    parameter int IDX_W   = $clog2(SEG_CNT)
) (
    input  logic [SEG_CNT*32-1:0] seg_flat,
    input  logic [IDX_W-1:0]      idx,
    output logic [VSID_W-1:0]     vsid
);
    logic [VSID_W-1:0] field [SEG_CNT];

    generate
        for (genvar g = 0; g < SEG_CNT; g++) begin : g_seg
            assign field[g] = seg_flat[g*32 +: VSID_W];
        end
    endgenerate

    assign vsid = field[idx];
endmodule

// File: rtl/pgw_hash.sv
module pgw_hash #(
    parameter int VSID_W = 24,
    parameter int MASK_W = 9,
    parameter int LOW_W  = 10
) (
    input  logic [VSID_W-1:0] vsid,
    input  logic [15:0]       page_idx,
    input  logic [5:0]        api,
    input  logic              secondary,
    input  logic [MASK_W-1:0] size_mask,
    output logic [31:0]       group_off,
    output logic [31:0]       search_key
);
    localparam int HW = pgw_pkg::HASH_W;

    logic [HW-1:0]     h_pri;
    logic [HW-1:0]     h_sel;
    logic [MASK_W-1:0] upper;

    always_comb begin
        h_pri = {{(HW-16){1'b0}}, page_idx} ^ vsid[HW-1:0];
        h_sel = secondary ? ~h_pri : h_pri;
        upper = h_sel[LOW_W +: MASK_W] & size_mask;
        group_off = ({{(32-MASK_W){1'b0}}, upper} << 16)
                  | ({{(32-LOW_W){1'b0}}, h_sel[LOW_W-1:0]} << 6);
        search_key = {1'b1, vsid, secondary, api};
    end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker #(
    parameter int SEG_CNT     = 16,
    parameter int VSID_W      = 24,
    parameter int GROUP_SLOTS = 8,
    parameter int MASK_W      = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [31:0]           req_ea,
    input  logic                  req_write,
    input  logic                  req_data_side,
    input  logic [SEG_CNT*32-1:0] seg_regs,
    input  logic [31:0]           table_base,
    output logic                  busy,
    output logic                  mem_req,
    output logic [31:0]           mem_addr,
    input  logic                  mem_valid,
    input  logic [31:0]           mem_rdata,
    output logic                  done,
    output logic                  fault,
    output logic [31:0]           pa,
    input  logic                  ack,
    output logic [1:0]            fault_status,
    output logic [31:0]           fault_addr
);
    import pgw_pkg::*;

    localparam int SEG_IDX_W = $clog2(SEG_CNT);
    localparam int SLOT_W    = $clog2(GROUP_SLOTS);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(GROUP_SLOTS - 1);
    localparam int ENT_SH    = 3;

    walk_state_t state_q, state_d;

    logic [31:0]        ea_q;
    logic               write_q;
    logic               dside_q;
    logic [VSID_W-1:0]  vsid_q;
    logic [31:0]        base_q;
    logic               sec_q;
    logic [SLOT_W-1:0]  slot_q;
    logic [31:0]        key_word_q;
    logic [31:0]        pa_q;
    logic [1:0]         status_q;
    logic [31:0]        faddr_q;

    logic [VSID_W-1:0]  vsid_sel;
    logic [31:0]        group_off;
    logic [31:0]        search_key;
    logic [31:0]        key_addr;
    logic               key_hit;
    logic               entering_fault;
    logic [31:0]        cap_ea;
    logic               cap_write;
    logic               cap_dside;

    pgw_seg_mux #(.SEG_CNT(SEG_CNT), .VSID_W(VSID_W)) u_seg (
        .seg_flat (seg_regs),
        .idx      (req_ea[31 -: SEG_IDX_W]),
        .vsid     (vsid_sel)
    );

    pgw_hash #(.VSID_W(VSID_W), .MASK_W(MASK_W)) u_hash (
        .vsid       (vsid_q),
        .page_idx   (ea_q[27:12]),
        .api        (ea_q[27:22]),
        .secondary  (sec_q),
        .size_mask  (base_q[MASK_W-1:0]),
        .group_off  (group_off),
        .search_key (search_key)
    );

    assign key_addr = {base_q[31:16], 16'h0} | group_off
                    | {{(32-SLOT_W-ENT_SH){1'b0}}, slot_q, {ENT_SH{1'b0}}};
    assign key_hit  = (key_word_q == search_key);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:       if (req_valid)
                              state_d = (table_base == 32'h0) ? S_FAULT : S_FETCH_KEY;
            S_FETCH_KEY:  if (mem_valid) state_d = S_COMPARE;
            S_COMPARE: begin
                if (key_hit)                state_d = S_FETCH_DATA;
                else if (slot_q != LAST_SLOT) state_d = S_FETCH_KEY;
                else if (!sec_q)            state_d = S_FETCH_KEY;
                else                        state_d = S_FAULT;
            end
            S_FETCH_DATA: if (mem_valid) state_d = S_DONE;
            S_DONE:       if (ack) state_d = S_IDLE;
            S_FAULT:      if (ack) state_d = S_IDLE;
            default:      state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    assign cap_ea         = (state_q == S_IDLE) ? req_ea        : ea_q;
    assign cap_write      = (state_q == S_IDLE) ? req_write     : write_q;
    assign cap_dside      = (state_q == S_IDLE) ? req_data_side : dside_q;
    assign entering_fault = (state_d == S_FAULT) && (state_q != S_FAULT);

    // walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q       <= '0;
            write_q    <= 1'b0;
            dside_q    <= 1'b0;
            vsid_q     <= '0;
            base_q     <= '0;
            sec_q      <= 1'b0;
            slot_q     <= '0;
            key_word_q <= '0;
            pa_q       <= '0;
            status_q   <= '0;
            faddr_q    <= '0;
        end else begin
            if (state_q == S_IDLE && req_valid) begin
                ea_q    <= req_ea;
                write_q <= req_write;
                dside_q <= req_data_side;
                vsid_q  <= vsid_sel;
                base_q  <= table_base;
                sec_q   <= 1'b0;
                slot_q  <= '0;
            end
            if (state_q == S_FETCH_KEY && mem_valid)
                key_word_q <= mem_rdata;
            if (state_q == S_COMPARE && !key_hit) begin
                if (slot_q == LAST_SLOT) begin
                    slot_q <= '0;
                    sec_q  <= 1'b1;
                end else begin
                    slot_q <= slot_q + SLOT_W'(1);
                end
            end
            if (state_q == S_FETCH_DATA && mem_valid)
                pa_q <= {mem_rdata[31:pgw_pkg::PAGE_SH], ea_q[pgw_pkg::PAGE_SH-1:0]};
            if (entering_fault && cap_dside) begin
                status_q <= {cap_write, 1'b1};
                faddr_q  <= cap_ea;
            end
        end
    end

    // outputs
    always_comb begin
        busy         = (state_q != S_IDLE);
        mem_req      = (state_q == S_FETCH_KEY) || (state_q == S_FETCH_DATA);
        mem_addr     = key_addr | ((state_q == S_FETCH_DATA) ? 32'h4 : 32'h0);
        done         = (state_q == S_DONE);
        fault        = (state_q == S_FAULT);
        pa           = pa_q;
        fault_status = status_q;
        fault_addr   = faddr_q;
    end

    // assertions
    p_data_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fault) && dside_q) |-> (fault_status[0] && fault_addr == ea_q));

    p_ifault_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fault) && !dside_q) |-> ($stable(fault_status) && $stable(fault_addr)));

    p_zero_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && table_base == 32'h0) |=> (fault && !mem_req));

    p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ack) |=> (done && $stable(pa)));

    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, fault, mem_req}));

    p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));
endmodule

// File: tb/tb_hpt_walker.sv
module tb_hpt_walker;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [31:0]   req_ea = '0;
    logic          req_write = 1'b0;
    logic          req_data_side = 1'b0;
    logic [511:0]  seg_regs;
    logic [31:0]   table_base = 32'h0080_0000;
    logic          busy, mem_req, done, fault;
    logic [31:0]   mem_addr, pa, fault_addr;
    logic          mem_valid = 1'b0;
    logic [31:0]   mem_rdata = '0;
    logic          ack = 1'b0;
    logic [1:0]    fault_status;
    logic          stall = 1'b0;

    int checks = 0;
    int fails  = 0;
    int rd_count = 0;
    logic [31:0] mem [logic [31:0]];

    always #5 clk = ~clk;

    hpt_walker dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea),
        .req_write(req_write), .req_data_side(req_data_side), .seg_regs(seg_regs),
        .table_base(table_base), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata), .done(done), .fault(fault),
        .pa(pa), .ack(ack), .fault_status(fault_status), .fault_addr(fault_addr)
    );

    // memory model: one-cycle latency, optional stall
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_valid <= 1'b0;
        end else begin
            mem_valid <= mem_req && !mem_valid && !stall;
            mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
            if (mem_req && !mem_valid && !stall) rd_count <= rd_count + 1;
        end
    end

    function automatic logic [23:0] seg_vsid(input int i);
        return 24'h01_3579 + 24'(i) * 24'h03_2A1B;
    endfunction

    function automatic logic [31:0] ent_addr(input logic [31:0] base, input logic [23:0] vsid,
                                             input logic [31:0] ea, input bit sec, input int slot);
        logic [22:0] h;
        logic [8:0]  up;
        h = {7'd0, ea[27:12]} ^ vsid[22:0];
        if (sec) h = ~h;
        up = h[18:10] & base[8:0];
        return {base[31:16], 16'h0} | ({23'd0, up} << 16) | ({22'd0, h[9:0]} << 6) | (32'(slot) * 8);
    endfunction

    task automatic place(input logic [31:0] base, input logic [31:0] ea, input bit grp_sec,
                         input bit key_sec, input int slot, input logic [19:0] rpn);
        logic [23:0] v;
        logic [31:0] a;
        v = seg_vsid(int'(ea[31:28]));
        a = ent_addr(base, v, ea, grp_sec, slot);
        mem[a]         = {1'b1, v, key_sec, ea[27:22]};
        mem[a + 32'd4] = {rpn, 12'h192};
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic        r_fault;
    logic [31:0] r_pa;
    int          r_reads;

    task automatic issue(input logic [31:0] ea, input bit wr, input bit ds);
        @(negedge clk);
        req_valid = 1'b1; req_ea = ea; req_write = wr; req_data_side = ds;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_result();
        for (int n = 0; n < 200 && !(done || fault); n++) @(negedge clk);
        r_fault = fault;
        r_pa    = pa;
    endtask

    task automatic release_result();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic walk(input logic [31:0] ea, input bit wr, input bit ds);
        int start;
        start = rd_count;
        issue(ea, wr, ds);
        wait_result();
        r_reads = rd_count - start;
        release_result();
    endtask

    localparam int NV = 6;
    localparam logic [31:0] V_EA   [NV] = '{32'h1000_3ABC, 32'h2345_6123, 32'h3000_5000,
                                            32'h4000_7000, 32'h5000_8000, 32'h6000_9FFF};
    localparam bit          V_WR   [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
    localparam bit          V_DS   [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
    localparam bit          V_HIT  [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
    localparam bit          V_SEC  [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
    localparam int          V_SLOT [NV] = '{0, 7, 2, 0, 0, 7};
    localparam logic [19:0] V_RPN  [NV] = '{20'h00ABC, 20'h12345, 20'h55555, 20'h0, 20'h0, 20'h0FFFF};

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [1:0]  exp_st;
        logic [31:0] exp_fa;
        logic [31:0] a0;
        int          exp_reads;
        for (int i = 0; i < 16; i++) seg_regs[i*32 +: 32] = {8'hC3, seg_vsid(i)};
        for (int i = 0; i < NV; i++)
            if (V_HIT[i]) place(table_base, V_EA[i], V_SEC[i], V_SEC[i], V_SLOT[i], V_RPN[i]);
        // decoy: select bit set, sitting in the primary group of vector 2
        place(table_base, V_EA[2], 1'b0, 1'b1, 0, 20'hBAD00);

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 done/fault/mem_req", {29'd0, done, fault, mem_req}, 32'd0);
        chk("R1 fault_status", {30'd0, fault_status}, 32'd0);
        chk("R1 fault_addr", fault_addr, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table: R3 R4 R5 R6 R7
        exp_st = 2'b00; exp_fa = 32'h0;
        for (int i = 0; i < NV; i++) begin
            walk(V_EA[i], V_WR[i], V_DS[i]);
            if (V_HIT[i]) begin
                chk($sformatf("R5 pa vec%0d", i), r_pa, {V_RPN[i], V_EA[i][11:0]});
                exp_reads = (V_SEC[i] ? 8 : 0) + V_SLOT[i] + 2;
                chk($sformatf("R3/R4 reads vec%0d", i), 32'(r_reads), 32'(exp_reads));
            end else begin
                chk($sformatf("R6 fault vec%0d", i), {31'd0, r_fault}, 32'd1);
                chk($sformatf("R4 reads vec%0d", i), 32'(r_reads), 32'd16);
                if (V_DS[i]) begin exp_st = {V_WR[i], 1'b1}; exp_fa = V_EA[i]; end
            end
            chk($sformatf("R6/R7 status vec%0d", i), {30'd0, fault_status}, {30'd0, exp_st});
            chk($sformatf("R6/R7 addr vec%0d", i), fault_addr, exp_fa);
            chk($sformatf("R10 idle after ack vec%0d", i), {31'd0, busy}, 32'd0);
        end

        // R8 zero table base
        table_base = 32'h0;
        walk(32'h7000_1234, 1'b0, 1'b1);
        chk("R8 fault", {31'd0, r_fault}, 32'd1);
        chk("R8 no reads", 32'(r_reads), 32'd0);
        chk("R6 read status", {30'd0, fault_status}, 32'd1);
        chk("R6 read addr", fault_addr, 32'h7000_1234);
        table_base = 32'h0080_0000;

        // R2 size mask in the group address
        table_base = 32'h0100_01FF;
        place(table_base, 32'h7ABC_D123, 1'b0, 1'b0, 3, 20'h7C0DE);
        walk(32'h7ABC_D123, 1'b0, 1'b1);
        chk("R2 masked group pa", r_pa, 32'h7C0D_E123);
        chk("R2 masked group reads", 32'(r_reads), 32'd5);
        table_base = 32'h0080_0000;

        // R11 and R2: stalled memory keeps the request and address
        stall = 1'b1;
        a0 = ent_addr(table_base, seg_vsid(1), V_EA[0], 1'b0, 0);
        issue(V_EA[0], 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        chk("R11 mem_req held", {31'd0, mem_req}, 32'd1);
        chk("R2 key address", mem_addr, a0);
        stall = 1'b0;
        wait_result();
        chk("R11 pa after stall", r_pa, {V_RPN[0], V_EA[0][11:0]});
        // R10 hold without ack
        repeat (5) @(negedge clk);
        chk("R10 done held", {31'd0, done}, 32'd1);
        chk("R10 pa held", pa, {V_RPN[0], V_EA[0][11:0]});
        release_result();
        chk("R10 idle", {30'd0, done, busy}, 32'd0);

        // R9 requests while busy are ignored
        issue(V_EA[0], 1'b0, 1'b1);
        req_valid = 1'b1; req_ea = V_EA[1]; req_write = 1'b0;
        chk("R9 busy", {31'd0, busy}, 32'd1);
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        wait_result();
        chk("R9 first request result", r_pa, {V_RPN[0], V_EA[0][11:0]});
        release_result();
        repeat (2) @(negedge clk);
        chk("R9 stray not accepted", {31'd0, busy}, 32'd0);

        finish_run();
    end
endmodule